// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block stands in for the device side of the status mechanism of a parallel NOR flash. It keeps track of three things: whether an internal program is running, whether an internal erase is running, and whether an erase has been suspended. On every read strobe it registers three status data bits, called bit 7, bit 6 and bit 2. While an operation is under way these bits carry a status pattern in place of array data. The block also drives an open-drain ready/busy line, modelled as a pull-low enable. A command decoder outside the block sends it one-cycle start, suspend and resume pulses. A memory array outside the block supplies the true array bits, which the block passes through whenever no status pattern applies.

The state machine has five states:

| State | Meaning |
|---|---|
| `ST_IDLE` | No operation is running. |
| `ST_PROG` | A program is running. |
| `ST_ERASE` | An erase is running. |
| `ST_SUSP` | The erase is suspended. |
| `ST_SPROG` | A program is running while the erase is suspended. |

The transitions are:

| Transition | From | To | Taken when |
|---|---|---|---|
| idle-to-program | `ST_IDLE` | `ST_PROG` | `prog_go` is high. |
| idle-to-erase | `ST_IDLE` | `ST_ERASE` | `erase_go` is high and `prog_go` is low. |
| program-done | `ST_PROG` | `ST_IDLE` | The program countdown has expired. |
| erase-done | `ST_ERASE` | `ST_IDLE` | The erase countdown has expired. |
| suspend | `ST_ERASE` | `ST_SUSP` | `suspend_req` is high and the erase countdown has not expired. |
| resume | `ST_SUSP` | `ST_ERASE` | `resume_req` is high. |
| suspended-program | `ST_SUSP` | `ST_SPROG` | `prog_go` is high, `sect_hit` is low and `resume_req` is low. |
| suspended-program-done | `ST_SPROG` | `ST_SUSP` | The program countdown has expired. |

Two countdowns time the operations, one for program and one for erase. Their lengths in clock cycles are set by parameters. The erase countdown is frozen while the erase is suspended. The toggle flip-flops behind bits 6 and 2 change only on read strobes.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the state is `ST_IDLE`, `rb_pull_low` is 0 and all three status outputs are 0.
- R2: A `prog_go` pulse in `ST_IDLE` latches `prog_bit` and drives `rb_pull_low` high for exactly `PROG_CYCLES` cycles, starting in the cycle after the pulse. After that the block returns to `ST_IDLE`.
- R3: An `erase_go` pulse in `ST_IDLE` starts an erase that needs `ERASE_CYCLES` cycles of progress. If `prog_go` and `erase_go` arrive together, the program is started.
- R4: A read strobe during a program registers bit 7 as the complement of the latched data bit. Bit 6 shows the bit-6 toggle value and then the toggle inverts. Bit 2 shows the bit-2 toggle value, which does not change.
- R5: A read strobe during an erase registers bit 7 = 0. Bits 6 and 2 each show their toggle value and then both toggles invert.
- R6: Any accepted start clears both toggles to 0, so the first read after a start returns 0 on bits 6 and 2. Without a read strobe, neither toggle changes.
- R7: `suspend_req` in `ST_ERASE` moves the block to `ST_SUSP` and releases `rb_pull_low`. That cycle makes no erase progress. The remaining erase count is held until `resume_req` returns the block to `ST_ERASE`.
- R8: In `ST_SUSP`, a read with `sect_hit` high returns bit 7 = 1, bit 6 = 1 and the bit-2 toggle value, and then inverts that toggle. A read with `sect_hit` low returns the array bits.
- R9: In `ST_SUSP`, a `prog_go` with `sect_hit` low starts a program that drives `rb_pull_low` for `PROG_CYCLES` cycles. During it, reads behave as in R4. When it ends, the block returns to `ST_SUSP`. A `prog_go` with `sect_hit` high is ignored.
- R10: In `ST_IDLE` a read returns `arr_bits`, where `arr_bits[2]` maps to bit 7, `arr_bits[1]` to bit 6 and `arr_bits[0]` to bit 2. Start pulses that arrive during `ST_PROG` or `ST_ERASE` are ignored.
- R11: The status outputs change only in the cycle after a read strobe and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_go | input | 1 | Program start pulse |
| erase_go | input | 1 | Erase start pulse |
| suspend_req | input | 1 | Erase suspend pulse |
| resume_req | input | 1 | Erase resume pulse |
| rd_stb | input | 1 | Read strobe, one cycle |
| sect_hit | input | 1 | High when the addressed sector is the suspended one |
| prog_bit | input | 1 | True value of the bit being programmed |
| arr_bits | input | 3 | Array data for bits 7, 6 and 2 |
| stat_b7 | output | 1 | Status or data bit 7 |
| stat_b6 | output | 1 | Status or data bit 6 |
| stat_b2 | output | 1 | Status or data bit 2 |
| rb_pull_low | output | 1 | Ready/busy pull-low enable; 1 means busy |

## Verification
The bench builds the block with `PROG_CYCLES` = 5 and `ERASE_CYCLES` = 12. With lengths this short, a random stream of starts, suspends and resumes runs hundreds of complete operations to completion. The short lengths also bring the exact-boundary cases within reach: a suspend request landing on the last erase cycle, a resume arriving together with a program start, and a read issued in the same cycle as a start. The directed part counts busy cycles around a suspend and resume to confirm that the frozen count is preserved.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SPROG
    } fsg_state_e;

    typedef struct packed {
        logic b7;
        logic b6;
        logic b2;
    } stat_bits_t;

    function automatic logic state_busy(fsg_state_e s);
        return (s == ST_PROG) || (s == ST_ERASE) || (s == ST_SPROG);
    endfunction

endpackage

// File: rtl/fsg_countdown.sv
module fsg_countdown #(
    parameter int unsigned LENGTH = 4,
    localparam int unsigned W = (LENGTH < 2) ? 1 : $clog2(LENGTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);
    localparam logic [W-1:0] LOAD_VAL = W'(LENGTH - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R7: no load and no run means the remaining count is frozen
    assert_count_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt));

endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (clr) begin
            q <= 1'b0;
        end else if (adv) begin
            q <= ~q;
        end
    end

    assert_toggle_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (q != $past(q)));

    assert_toggle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(q));

endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
    import fsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_go,
    input  logic       erase_go,
    input  logic       suspend_req,
    input  logic       resume_req,
    input  logic       sect_hit,
    input  logic       p_zero,
    input  logic       e_zero,
    output fsg_state_e st,
    output logic       p_load,
    output logic       e_load,
    output logic       p_run,
    output logic       e_run
);
    fsg_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt    = st;
        p_load = 1'b0;
        e_load = 1'b0;
        p_run  = 1'b0;
        e_run  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (prog_go) begin
                    nxt    = ST_PROG;
                    p_load = 1'b1;
                end else if (erase_go) begin
                    nxt    = ST_ERASE;
                    e_load = 1'b1;
                end
            end
            ST_PROG: begin
                if (p_zero) nxt = ST_IDLE;
                else        p_run = 1'b1;
            end
            ST_SPROG: begin
                if (p_zero) nxt = ST_SUSP;
                else        p_run = 1'b1;
            end
            ST_ERASE: begin
                if (e_zero)           nxt = ST_IDLE;
                else if (suspend_req) nxt = ST_SUSP;
                else                  e_run = 1'b1;
            end
            ST_SUSP: begin
                if (resume_req) begin
                    nxt = ST_ERASE;
                end else if (prog_go && !sect_hit) begin
                    nxt    = ST_SPROG;
                    p_load = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assert_prog_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && p_zero) |=> (st == ST_IDLE));

    assert_sprog_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SPROG && p_zero) |=> (st == ST_SUSP));

    assert_susp_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP && !resume_req) |=> (st == ST_SUSP || st == ST_SPROG));

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && !p_zero) |=> (st == ST_PROG));

endmodule

// File: rtl/fsg_rdmux.sv
module fsg_rdmux
    import fsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fsg_state_e st,
    input  logic       rd_stb,
    input  logic       sect_hit,
    input  logic       p_load,
    input  logic       prog_bit,
    input  logic [2:0] arr_bits,
    input  logic       t6,
    input  logic       t2,
    output stat_bits_t q
);
    logic       held_bit;
    stat_bits_t nxt_q;
    stat_bits_t arr_view;

    assign arr_view = '{b7: arr_bits[2], b6: arr_bits[1], b2: arr_bits[0]};

    always_comb begin
        unique case (st)
            ST_IDLE:           nxt_q = arr_view;
            ST_PROG, ST_SPROG: nxt_q = '{b7: ~held_bit, b6: t6, b2: t2};
            ST_ERASE:          nxt_q = '{b7: 1'b0, b6: t6, b2: t2};
            ST_SUSP:           nxt_q = sect_hit ? '{b7: 1'b1, b6: 1'b1, b2: t2} : arr_view;
            default:           nxt_q = arr_view;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            held_bit <= 1'b0;
        end else begin
            if (p_load) held_bit <= prog_bit;
            if (rd_stb) q <= nxt_q;
        end
    end

    assert_erase_b7_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == ST_ERASE) |=> !q.b7);

    assert_susp_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == ST_SUSP && sect_hit) |=> (q.b7 && q.b6));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(q));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int unsigned PROG_CYCLES  = 400,
    parameter int unsigned ERASE_CYCLES = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_go,
    input  logic       erase_go,
    input  logic       suspend_req,
    input  logic       resume_req,
    input  logic       rd_stb,
    input  logic       sect_hit,
    input  logic       prog_bit,
    input  logic [2:0] arr_bits,
    output logic       stat_b7,
    output logic       stat_b6,
    output logic       stat_b2,
    output logic       rb_pull_low
);
    localparam int NTOG = 2;

    fsg_state_e      st;
    logic            p_load, e_load, p_run, e_run, p_zero, e_zero;
    logic [NTOG-1:0] tog_adv, tog_q;
    stat_bits_t      q;

    fsg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
        .suspend_req(suspend_req), .resume_req(resume_req), .sect_hit(sect_hit),
        .p_zero(p_zero), .e_zero(e_zero), .st(st),
        .p_load(p_load), .e_load(e_load), .p_run(p_run), .e_run(e_run)
    );

    fsg_countdown #(.LENGTH(PROG_CYCLES)) u_pcnt (
        .clk(clk), .rst_n(rst_n), .load(p_load), .run(p_run), .zero(p_zero)
    );

    fsg_countdown #(.LENGTH(ERASE_CYCLES)) u_ecnt (
        .clk(clk), .rst_n(rst_n), .load(e_load), .run(e_run), .zero(e_zero)
    );

    // index 1: bit-6 toggle, index 0: bit-2 toggle
    assign tog_adv[1] = rd_stb && state_busy(st);
    assign tog_adv[0] = rd_stb && ((st == ST_ERASE) || (st == ST_SUSP && sect_hit));

    for (genvar g = 0; g < NTOG; g++) begin : g_tog
        fsg_toggle u_tog (
            .clk(clk), .rst_n(rst_n), .clr(p_load | e_load),
            .adv(tog_adv[g]), .q(tog_q[g])
        );
    end

    fsg_rdmux u_rdmux (
        .clk(clk), .rst_n(rst_n), .st(st), .rd_stb(rd_stb), .sect_hit(sect_hit),
        .p_load(p_load), .prog_bit(prog_bit), .arr_bits(arr_bits),
        .t6(tog_q[1]), .t2(tog_q[0]), .q(q)
    );

    assign stat_b7     = q.b7;
    assign stat_b6     = q.b6;
    assign stat_b2     = q.b2;
    assign rb_pull_low = state_busy(st);

    assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_pull_low) |-> $past(prog_go || erase_go || resume_req));

    assert_first_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(p_load || e_load) && rd_stb && state_busy(st)) |=> (!stat_b6));

endmodule

// File: tb/test_flash_status_gen.sv
`timescale 1ns/1ps
module test_flash_status_gen;
    localparam int PC = 5;
    localparam int EC = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic prog_go = 0, erase_go = 0, suspend_req = 0, resume_req = 0;
    logic rd_stb = 0, sect_hit = 0, prog_bit = 0;
    logic [2:0] arr_bits = 3'b000;
    logic stat_b7, stat_b6, stat_b2, rb_pull_low;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    flash_status_gen #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) i_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
        .suspend_req(suspend_req), .resume_req(resume_req), .rd_stb(rd_stb),
        .sect_hit(sect_hit), .prog_bit(prog_bit), .arr_bits(arr_bits),
        .stat_b7(stat_b7), .stat_b6(stat_b6), .stat_b2(stat_b2),
        .rb_pull_low(rb_pull_low)
    );

    // behavioural reference: 0 idle, 1 prog, 2 erase, 3 suspended, 4 program in suspend
    int    mst = 0, prem = 0, erem = 0;
    bit    pbit = 0, m6 = 0, m2 = 0;
    bit    o7 = 0, o6 = 0, o2 = 0;
    string dtag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; prem = 0; erem = 0; pbit = 0; m6 = 0; m2 = 0;
            o7 = 0; o6 = 0; o2 = 0; dtag = "R1";
        end else begin
            bit busy, sp, se, n6, n2;
            busy = (mst == 1) || (mst == 2) || (mst == 4);
            if (rd_stb) begin
                case (mst)
                    0: begin {o7, o6, o2} = arr_bits; dtag = "R10"; end
                    1: begin o7 = !pbit; o6 = m6; o2 = m2; dtag = "R4"; end
                    4: begin o7 = !pbit; o6 = m6; o2 = m2; dtag = "R9"; end
                    2: begin o7 = 0; o6 = m6; o2 = m2; dtag = "R5"; end
                    default: begin
                        if (sect_hit) begin o7 = 1; o6 = 1; o2 = m2; end
                        else {o7, o6, o2} = arr_bits;
                        dtag = "R8";
                    end
                endcase
            end
            sp = (mst == 0 && prog_go) || (mst == 3 && !resume_req && prog_go && !sect_hit);
            se = (mst == 0 && !prog_go && erase_go);
            n6 = m6; n2 = m2;
            if (rd_stb && busy) n6 = !m6;
            if (rd_stb && (mst == 2 || (mst == 3 && sect_hit))) n2 = !m2;
            if (sp || se) begin n6 = 0; n2 = 0; end
            m6 = n6; m2 = n2;
            case (mst)
                0: if (sp) begin mst = 1; prem = PC; pbit = prog_bit; end
                   else if (se) begin mst = 2; erem = EC; end
                1: if (prem == 1) mst = 0; else prem--;
                4: if (prem == 1) mst = 3; else prem--;
                2: if (erem == 1) mst = 0; else if (suspend_req) mst = 3; else erem--;
                default: if (resume_req) mst = 2;
                         else if (sp) begin mst = 4; prem = PC; pbit = prog_bit; end
            endcase
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            string btag;
            case (mst)
                0: btag = "R1"; 1: btag = "R2"; 2: btag = "R3";
                3: btag = "R7"; default: btag = "R9";
            endcase
            check(btag, "model rb_pull_low", rb_pull_low, (mst == 1 || mst == 2 || mst == 4));
            check(dtag, "model status bits", {stat_b7, stat_b6, stat_b2}, {o7, o6, o2});
        end
    end

    task automatic cyc(bit p = 0, bit e = 0, bit s = 0, bit r = 0, bit rd = 0,
                       bit hit = 0, bit d = 0, logic [2:0] a = 3'b000);
        prog_go = p; erase_go = e; suspend_req = s; resume_req = r;
        rd_stb = rd; sect_hit = hit; prog_bit = d; arr_bits = a;
        @(negedge clk);
        prog_go = 0; erase_go = 0; suspend_req = 0; resume_req = 0; rd_stb = 0;
    endtask

    task automatic stat(string tag, logic [2:0] exp);
        check(tag, "status bits", {stat_b7, stat_b6, stat_b2}, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset rb_pull_low", rb_pull_low, 0);
        stat("R1", 3'b000);
        rst_n = 1;
        @(negedge clk);

        cyc(.rd(1), .a(3'b101));
        stat("R10", 3'b101);

        // program with data 1
        cyc(.p(1), .d(1));
        check("R2", "busy after program start", rb_pull_low, 1);
        for (int i = 1; i < PC; i++) begin
            cyc(.rd(i <= 2));
            check("R2", "busy during program", rb_pull_low, 1);
            if (i == 1) stat("R6", 3'b000);
            if (i == 2) stat("R4", 3'b010);
            if (i == 3) stat("R11", 3'b010);
        end
        cyc();
        check("R2", "ready after program", rb_pull_low, 0);

        // both starts together: program wins
        cyc(.p(1), .e(1), .d(0));
        cyc(.rd(1));
        stat("R3", 3'b100);
        cyc(.e(1));
        for (int i = 0; i < PC - 2; i++) cyc();
        check("R10", "erase start ignored while programming", rb_pull_low, 0);

        // erase with suspend/resume
        cyc(.e(1));
        cyc(.rd(1));
        stat("R6", 3'b000);
        cyc(.rd(1));
        stat("R5", 3'b011);
        cyc(.s(1));
        check("R7", "ready while suspended", rb_pull_low, 0);
        cyc(.rd(1), .hit(1));
        stat("R8", 3'b110);
        cyc(.rd(1), .hit(1));
        stat("R8", 3'b111);
        cyc(.rd(1), .hit(0), .a(3'b010));
        stat("R8", 3'b010);
        cyc(.p(1), .hit(1), .d(0));
        check("R9", "program into suspended sector ignored", rb_pull_low, 0);
        cyc(.p(1), .hit(0), .d(0));
        check("R9", "busy for program in suspend", rb_pull_low, 1);
        cyc(.rd(1));
        stat("R9", 3'b100);
        cyc(.rd(1));
        stat("R9", 3'b110);
        for (int i = 0; i < PC - 2; i++) cyc();
        check("R9", "back to suspended", rb_pull_low, 0);
        cyc(.rd(1), .hit(1));
        stat("R9", 3'b110);
        cyc(.r(1));
        begin
            int n = 0;
            while (rb_pull_low && n < 100) begin n++; cyc(); end
            check("R7", "busy cycles after resume", n, EC - 2);
        end
        cyc(.rd(1), .a(3'b111));
        stat("R10", 3'b111);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            cyc(.p($urandom_range(99) < 3), .e($urandom_range(99) < 3),
                .s($urandom_range(99) < 6), .r($urandom_range(99) < 6),
                .rd($urandom_range(99) < 40), .hit($urandom_range(1) == 1),
                .d($urandom_range(1) == 1), .a(3'($urandom_range(7))));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500us;
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule